// File: doc/BRIEF.md
# Gated Event Timer with Edge-Staggered Comparator Gate

This block is a free-running up-counter for timing analog and digital events. A slow timer clock source, sampled in the system clock domain, passes through a power-of-two prescaler. Each rising edge of the prescaled clock advances the counter, but only while the timer is switched on and the chosen gate is active. The gate comes either from an external gate pin or from the output of a comparator. The gate polarity is selectable.

When the comparator drives the gate, an optional capture register can hold the comparator level. It is loaded on the falling edge of the prescaled clock. The counter then steps on the next rising edge, half a prescaled period later. A comparator transition close to an increment therefore cannot produce a lost or half-formed count. A rollover of the counter sets a sticky overflow flag. Software clears the flag, and software can also load the counter.

Top module: `gated_timer`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `count` is 0 and `ovf` is 0.
- R2: `ps_sel` picks the prescale ratio: 0 gives 1, 1 gives 2, 2 gives 4 and 3 gives 8. Counting source rising edges since the last counter load as n = 1, 2, ..., a prescaled rising edge occurs on every source rise for ratio 1, and where n mod ratio equals ratio/2 for the larger ratios. Each prescaled rising edge with the timer on and the gate active adds exactly 1 to `count`.
- R3: An increment from all ones to 0 sets `ovf`. `ovf` stays set until `ovf_clr` is pulsed, and a set in the same cycle wins over the clear.
- R4: With `tmr_on` low, `count` does not change, except by a load. The prescaler keeps advancing.
- R5: With `gate_sel` low, `gate_pin` is the gate. With `gate_hi` low, the gate is active when it is 0. With `gate_hi` high, the gate is active when it is 1.
- R6: With `gate_sel` high and `sync_en` low, the level of `cmp2_out` at the time of the increment is the gate.
- R7: With `gate_sel` high and `sync_en` high, the gate is the `cmp2_out` level captured at the most recent prescaled falling edge. That edge is the source falling edge for ratio 1, and the source rise where n mod ratio is 0 for the larger ratios. A comparator change after the capture has no effect on the following increment.
- R8: A `cnt_wr` pulse loads `cnt_wdata` into `count` on the next clock edge and wins over an increment in the same cycle. The same pulse restarts the prescaler phase (n restarts from 0) and loads the current `cmp2_out` into the capture register.
- R9: Between loads, `count` changes by at most +1 per clock cycle. An increment appears no later than the third clock edge after the source rising edge that causes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tmr_src | input | 1 | Timer clock source level, slower than clk |
| ps_sel | input | 2 | Prescale ratio select |
| tmr_on | input | 1 | Timer enable |
| gate_sel | input | 1 | 0: gate pin, 1: comparator |
| sync_en | input | 1 | Use captured comparator level |
| gate_hi | input | 1 | Gate polarity, 1 = active high |
| gate_pin | input | 1 | External gate input |
| cmp2_out | input | 1 | Comparator output |
| cnt_wr | input | 1 | Counter load strobe |
| cnt_wdata | input | 16 | Counter load value |
| ovf_clr | input | 1 | Overflow flag clear strobe |
| count | output | 16 | Counter value |
| ovf | output | 1 | Sticky overflow flag |

## Verification
A wrong prescaler phase shows up as a count that is one too high or too low. This becomes visible at the first prescaled period after a load, within at most eight source pulses. A wrong capture register or gate select shows up in the directed race case as a missing or extra count. That case is built so that the comparator changes between the capture and the increment, and the mismatch appears within three clock edges of the source rise. A wrong overflow flag appears as soon as the counter wraps, and it stays visible because the flag is sticky.

// File: rtl/gated_timer.sv
module gated_timer #(
  parameter int CNT_W = 16,
  parameter int PS_W  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tmr_src,
  input  logic [PS_W-1:0]  ps_sel,
  input  logic             tmr_on,
  input  logic             gate_sel,
  input  logic             sync_en,
  input  logic             gate_hi,
  input  logic             gate_pin,
  input  logic             cmp2_out,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] cnt_wdata,
  input  logic             ovf_clr,
  output logic [CNT_W-1:0] count,
  output logic             ovf
);
  localparam int PC_W = (1 << PS_W) - 1;

  logic            src_q, src_qq;
  logic [PC_W-1:0] pcnt;
  logic            pclk, pclk_q;
  logic            cmp_lat;
  logic            gate_raw, step;

  wire src_rise  = src_q & ~src_qq;
  wire pclk_rise = pclk & ~pclk_q;
  wire pclk_fall = ~pclk & pclk_q;

  assign pclk     = (ps_sel == '0) ? src_q : pcnt[ps_sel - 1'b1];
  assign gate_raw = gate_sel ? (sync_en ? cmp_lat : cmp2_out) : gate_pin;
  assign step     = tmr_on & (gate_raw == gate_hi) & pclk_rise;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_q  <= 1'b0;
      src_qq <= 1'b0;
      pclk_q <= 1'b0;
    end else begin
      src_q  <= tmr_src;
      src_qq <= src_q;
      pclk_q <= pclk;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        pcnt <= '0;
    else if (cnt_wr)   pcnt <= '0;
    else if (src_rise) pcnt <= pcnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                  cmp_lat <= 1'b0;
    else if (cnt_wr | pclk_fall) cmp_lat <= cmp2_out;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      count <= '0;
    else if (cnt_wr) count <= cnt_wdata;
    else if (step)   count <= count + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                             ovf <= 1'b0;
    else if (step && !cnt_wr && &count)     ovf <= 1'b1;
    else if (ovf_clr)                       ovf <= 1'b0;
  end
endmodule

// File: rtl/gated_timer_chk.sv
module gated_timer_chk #(
  parameter int CNT_W = 16,
  parameter int PS_W  = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tmr_on,
  input logic             cnt_wr,
  input logic [CNT_W-1:0] cnt_wdata,
  input logic             ovf_clr,
  input logic [CNT_W-1:0] count,
  input logic             ovf
);
  p_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> (count == '0 && !ovf));

  p_hold_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(tmr_on) && !$past(cnt_wr)) |-> $stable(count));

  p_ovf_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(cnt_wr) && $past(&count) && count == '0) |-> ovf);

  p_ovf_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(ovf) && !$past(ovf_clr)) |-> ovf);

  p_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(cnt_wr)) |-> count == $past(cnt_wdata));

  p_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(cnt_wr)) |->
      (count == $past(count) || count == $past(count) + 1'b1));
endmodule

bind gated_timer gated_timer_chk #(.CNT_W(CNT_W), .PS_W(PS_W)) chk_i (.*);

// File: tb/gated_timer_tb_top.sv
module gated_timer_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tmr_src = 0, tmr_on = 0, gate_sel = 0, sync_en = 0, gate_hi = 0;
  logic gate_pin = 0, cmp2_out = 0, cnt_wr = 0, ovf_clr = 0;
  logic [1:0]  ps_sel = 0;
  logic [15:0] cnt_wdata = 0;
  logic [15:0] count;
  logic        ovf;

  always #10 clk = ~clk;

  gated_timer dut_i (.*);

  int checks = 0, errors = 0;
  bit done = 0;
  logic [15:0] m_cnt = 0;
  bit m_ovf = 0, m_lat = 0;
  int m_n = 0;

  function automatic bit gate_ok();
    bit g;
    g = gate_sel ? (sync_en ? m_lat : cmp2_out) : gate_pin;
    return g == gate_hi;
  endfunction

  function automatic bit is_tick(int n, int r);
    return (r == 1) || (n % r == r / 2);
  endfunction

  task automatic chk(string tag);
    checks++;
    if (count !== m_cnt || ovf !== m_ovf) begin
      errors++;
      $display("FAIL %s count=%h ovf=%b expected count=%h ovf=%b", tag, count, ovf, m_cnt, m_ovf);
    end
  endtask

  task automatic load(logic [15:0] v, logic [1:0] ps, bit on, bit gs, bit sy, bit gh, bit pin, bit cmp);
    @(negedge clk);
    ps_sel = ps; tmr_on = on; gate_sel = gs; sync_en = sy; gate_hi = gh;
    gate_pin = pin; cmp2_out = cmp; cnt_wdata = v; cnt_wr = 1;
    @(negedge clk);
    cnt_wr = 0;
    m_cnt = v; m_n = 0; m_lat = cmp;
    repeat (3) @(negedge clk);
  endtask

  task automatic pulse(int h, int l, bit chg, bit newcmp);
    int r;
    r = 1 << ps_sel;
    tmr_src = 1;
    m_n++;
    if (is_tick(m_n, r) && tmr_on && gate_ok()) begin
      if (m_cnt == 16'hFFFF) m_ovf = 1;
      m_cnt = m_cnt + 1;
    end
    if (r > 1 && m_n % r == 0) m_lat = cmp2_out;
    repeat (h) @(negedge clk);
    tmr_src = 0;
    if (r == 1) m_lat = cmp2_out;
    repeat (l / 2) @(negedge clk);
    if (chg) cmp2_out = newcmp;
    repeat (l - l / 2) @(negedge clk);
  endtask

  task automatic pulses(int k);
    for (int i = 0; i < k; i++) pulse(4, 8, 0, 0);
  endtask

  task automatic clr_ovf();
    @(negedge clk); ovf_clr = 1;
    @(negedge clk); ovf_clr = 0;
    m_ovf = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog count=%h expected completion", count);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    chk("R1 reset");
    rst_n = 1;
    @(negedge clk);
    chk("R1 after release");

    // R2 / R5: ratio 1, pin gate active low
    load(16'h0000, 2'd0, 1, 0, 0, 0, 0, 0);
    pulses(5);
    chk("R2 ratio1");
    checks++;
    if (count !== 16'd5) begin errors++; $display("FAIL R2 count=%0d expected 5", count); end

    // R2: other ratios, 16 pulses each
    for (int p = 1; p < 4; p++) begin
      load(16'h0000, p[1:0], 1, 0, 0, 0, 0, 0);
      pulses(16);
      chk("R2 ratio");
      checks++;
      if (count !== 16'(16 >> p)) begin
        errors++; $display("FAIL R2 count=%0d expected %0d", count, 16 >> p);
      end
    end

    // R5: pin inactive under active low, then active high
    load(16'h0040, 2'd0, 1, 0, 0, 0, 1, 0);
    pulses(4);
    chk("R5 pin inactive");
    load(16'h0040, 2'd0, 1, 0, 0, 1, 1, 0);
    pulses(4);
    chk("R5 active high");

    // R4: timer off
    load(16'h1234, 2'd0, 0, 0, 0, 0, 0, 0);
    pulses(6);
    chk("R4 off");

    // R6: async comparator, goes inactive before the rise
    load(16'h0000, 2'd0, 1, 1, 0, 0, 0, 0);
    pulse(4, 8, 1, 1);
    pulse(4, 8, 0, 0);
    chk("R6 async");
    checks++;
    if (count !== 16'd1) begin errors++; $display("FAIL R6 count=%0d expected 1", count); end

    // R7: sync comparator, same stimulus counts both
    load(16'h0000, 2'd0, 1, 1, 1, 0, 0, 0);
    pulse(4, 8, 1, 1);
    pulse(4, 8, 1, 0);
    pulse(4, 8, 0, 0);
    chk("R7 sync");
    checks++;
    if (count !== 16'd2) begin errors++; $display("FAIL R7 count=%0d expected 2", count); end

    // R7: sync at ratio 4
    load(16'h0000, 2'd2, 1, 1, 1, 0, 0, 0);
    for (int i = 0; i < 12; i++) pulse(4, 8, 1, i[2]);
    chk("R7 sync ratio4");

    // R3: overflow, sticky, clear
    load(16'hFFFE, 2'd0, 1, 0, 0, 0, 0, 0);
    pulses(3);
    chk("R3 wrap");
    checks++;
    if (ovf !== 1'b1 || count !== 16'd1) begin
      errors++; $display("FAIL R3 ovf=%b count=%h expected 1 0001", ovf, count);
    end
    pulses(2);
    chk("R3 sticky");
    clr_ovf();
    chk("R3 cleared");

    // R8: load restarts prescaler phase
    load(16'h0000, 2'd3, 1, 0, 0, 0, 0, 0);
    pulses(3);
    load(16'h0100, 2'd3, 1, 0, 0, 0, 0, 0);
    pulses(4);
    chk("R8 phase restart");
    checks++;
    if (count !== 16'h0101) begin errors++; $display("FAIL R8 count=%h expected 0101", count); end

    // R9: random segments
    for (int s = 0; s < 60; s++) begin
      logic [15:0] v;
      v = ($urandom % 3 == 0) ? 16'(16'hFFF0 + $urandom % 16) : 16'($urandom);
      if ($urandom % 4 == 0) clr_ovf();
      load(v, 2'($urandom), ($urandom % 5) != 0, 1'($urandom), 1'($urandom),
           1'($urandom), 1'($urandom), 1'($urandom));
      for (int k = 0; k < 1 + int'($urandom % 20); k++) begin
        pulse(4 + int'($urandom % 4), 8 + int'($urandom % 6), ($urandom % 4) == 0, 1'($urandom));
        chk("R9 random");
      end
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule